// File: doc/BRIEF.md
# Falling-Edge Strobe Watchdog with Three Selectable Periods

This block watches a processor's signs of life through one strobe input. A falling edge on the strobe is a kick. Each kick clears the elapsed-time count and starts a new period. If a whole period passes with no kick, the block sends one clock-wide timeout request to the system reset generator. A new period then starts by itself, so a processor that stays silent is flagged again once every period.

The period is picked by a two-bit select. The select stands in for a board pin that can be tied low, left open or tied high, and it chooses one of three fixed periods, nominally 150, 600 and 1200 ms. Time is counted in milliseconds. The millisecond tick comes from a parameterized divider on the system clock, so a simulation can use a small divisor. The strobe goes through a two-flop synchronizer, and edge detection runs on the synchronized copy. A "reset active" input from the supervisor holds the count at zero while the system is in reset. A fresh, full period starts once that input is released.

Top module: `strobe_watchdog`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `timeout_req` is 0 and the elapsed count starts from zero.
- R2: A high-to-low transition of `strobe` restarts the period. It is acted on three clock edges after the first clock edge that samples `strobe` low, which is the synchronizer delay plus the edge detector. If `strobe` stays high, or stays low, no kick occurs.
- R3: A low-to-high transition of `strobe` has no effect on the count.
- R4: With `period_sel` = 2'b00, a silent strobe raises `timeout_req` exactly `PERIOD_SHORT_MS` × `CLKS_PER_MS` clock cycles after the period started.
- R5: With `period_sel` = 2'b01, the timeout follows `PERIOD_MID_MS` × `CLKS_PER_MS` cycles after the period started.
- R6: With `period_sel` = 2'b10 or 2'b11, the timeout follows `PERIOD_LONG_MS` × `CLKS_PER_MS` cycles after the period started.
- R7: `timeout_req` is high for exactly one cycle. A new period starts at that cycle, so an idle strobe gives one pulse per period.
- R8: While `sup_reset_active` is 1, the count is held at zero and no timeout is raised. The first full period starts on the first clock edge after the input is released.
- R9: Under any mix of kicks, select changes and hold, the output matches a cycle-exact model. When a kick and an expiring millisecond arrive on the same edge, the kick wins and no timeout is raised.
- R10: If `period_sel` is changed to a shorter period after more milliseconds have elapsed than the new period allows, the timeout fires at the next millisecond boundary.
- R11: A low pulse on `strobe` that is sampled by at least one clock edge counts as exactly one kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_reset_active | input | 1 | Supervisor reset in progress; holds the count at zero |
| strobe | input | 1 | Asynchronous processor activity strobe; falling edge = kick |
| period_sel | input | 2 | 00 short, 01 mid, 10/11 long period |
| timeout_req | output | 1 | One-cycle timeout request to the reset generator |

## Verification
The bench drives the design alongside a model written with plain integers. The model tracks elapsed cycles and a three-deep history of the strobe, and the output is compared against it on every clock. A wrong millisecond count or divider phase moves a timeout pulse by at least one cycle, so it shows at the first expiry, one period after the fault at the latest. A synchronizer that drops or doubles a kick, or that reacts to a rising edge, shows within one short period as a pulse that is missing or extra. A hold that fails to clear the count shows as a pulse early in the first period after release.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        PSEL_SHORT    = 2'b00,
        PSEL_MID      = 2'b01,
        PSEL_LONG     = 2'b10,
        PSEL_LONG_ALT = 2'b11
    } psel_e;

    typedef struct packed {
        logic stage1;
        logic stage2;
        logic stage3;
    } sync_state_t;

endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic fall_o
);

    sync_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = async_in;
        st_d.stage2 = st_q.stage1;
        st_d.stage3 = st_q.stage2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fall_o = st_q.stage3 & ~st_q.stage2;

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o); // R11

endmodule

// File: rtl/wdt_ms_tick.sv
module wdt_ms_tick #(
    parameter int CLKS_PER_MS = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic tick_o
);

    localparam int DIV_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_MS - 1);

    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (clear_i) begin
            div_d = '0;
        end else if (div_q == DIV_LAST) begin
            div_d = '0;
        end else begin
            div_d = div_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign tick_o = (div_q == DIV_LAST);

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= DIV_LAST); // R4

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (div_q == '0)); // R8

endmodule

// File: rtl/wdt_period_lut.sv
module wdt_period_lut
    import wdt_pkg::*;
#(
    parameter int PERIOD_SHORT_MS = 150,
    parameter int PERIOD_MID_MS   = 600,
    parameter int PERIOD_LONG_MS  = 1200,
    parameter int MS_W            = 11
) (
    input  logic [1:0]      sel_i,
    output logic [MS_W-1:0] limit_o
);

    always_comb begin
        case (psel_e'(sel_i))
            PSEL_SHORT: limit_o = MS_W'(PERIOD_SHORT_MS);
            PSEL_MID:   limit_o = MS_W'(PERIOD_MID_MS);
            default:    limit_o = MS_W'(PERIOD_LONG_MS);
        endcase
    end

    always_comb begin
        assert (limit_o != '0); // R6
    end

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
    parameter int CLKS_PER_MS     = 200000,
    parameter int PERIOD_SHORT_MS = 150,
    parameter int PERIOD_MID_MS   = 600,
    parameter int PERIOD_LONG_MS  = 1200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sup_reset_active,
    input  logic       strobe,
    input  logic [1:0] period_sel,
    output logic       timeout_req
);

    localparam int MS_W = $clog2(PERIOD_LONG_MS + 1);

    typedef struct packed {
        logic [MS_W-1:0] ms;
        logic            timeout;
    } cnt_state_t;

    logic            kick;
    logic            tick;
    logic            clear;
    logic [MS_W-1:0] limit;
    logic [MS_W:0]   ms_next;
    cnt_state_t      st_d, st_q;

    wdt_edge_sync i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (strobe),
        .fall_o   (kick)
    );

    assign clear = sup_reset_active | kick;

    wdt_ms_tick #(
        .CLKS_PER_MS (CLKS_PER_MS)
    ) i_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .tick_o  (tick)
    );

    wdt_period_lut #(
        .PERIOD_SHORT_MS (PERIOD_SHORT_MS),
        .PERIOD_MID_MS   (PERIOD_MID_MS),
        .PERIOD_LONG_MS  (PERIOD_LONG_MS),
        .MS_W            (MS_W)
    ) i_lut (
        .sel_i   (period_sel),
        .limit_o (limit)
    );

    assign ms_next = {1'b0, st_q.ms} + (MS_W+1)'(1);

    always_comb begin
        st_d         = st_q;
        st_d.timeout = 1'b0;
        if (sup_reset_active) begin
            st_d.ms = '0;
        end else if (kick) begin
            st_d.ms = '0;
        end else if (tick) begin
            if (ms_next >= {1'b0, limit}) begin
                st_d.timeout = 1'b1;
                st_d.ms      = '0;
            end else begin
                st_d.ms = ms_next[MS_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign timeout_req = st_q.timeout;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_req |=> !timeout_req); // R7

    AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        sup_reset_active |=> (!timeout_req && st_q.ms == '0)); // R8

    AST_KICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (!timeout_req && st_q.ms == '0)); // R2

    AST_MS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ms < MS_W'(PERIOD_LONG_MS)); // R10

    AST_TIMEOUT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !timeout_req); // R4

endmodule

// File: tb/test_strobe_watchdog.sv
module test_strobe_watchdog;

    localparam int DIV = 4;
    localparam int PS  = 3;
    localparam int PM  = 5;
    localparam int PL  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hold = 1'b0;
    logic       strobe = 1'b1;
    logic [1:0] sel = 2'b00;
    logic       timeout_req;

    int    checks = 0;
    int    fails = 0;
    int    pulses = 0;
    string tag = "R1";

    // reference model state
    int elapsed = 0;
    int mdl_ms = 0;
    bit h1 = 0, h2 = 0, h3 = 0;
    bit exp_to = 0;

    always #2.5 clk = ~clk;

    strobe_watchdog #(
        .CLKS_PER_MS     (DIV),
        .PERIOD_SHORT_MS (PS),
        .PERIOD_MID_MS   (PM),
        .PERIOD_LONG_MS  (PL)
    ) i_strobe_watchdog (
        .clk              (clk),
        .rst_n            (rst_n),
        .sup_reset_active (hold),
        .strobe           (strobe),
        .period_sel       (sel),
        .timeout_req      (timeout_req)
    );

    function automatic int lim_of(input logic [1:0] s);
        if (s == 2'b00) return PS;
        if (s == 2'b01) return PM;
        return PL;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed = 0; h1 = 0; h2 = 0; h3 = 0; exp_to = 0;
        end else begin
            bit k;
            k = h3 & ~h2;
            h3 = h2; h2 = h1; h1 = strobe;
            exp_to = 0;
            if (hold || k) begin
                elapsed = 0;
            end else begin
                elapsed++;
                if ((elapsed % DIV) == 0 && (elapsed / DIV) >= lim_of(sel)) begin
                    exp_to = 1;
                    elapsed = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        checks++;
        if (timeout_req !== exp_to) begin
            fails++;
            $display("FAIL %s: timeout_req actual %0b expected %0b at %0t",
                     tag, timeout_req, exp_to, $time);
        end
        if (timeout_req === 1'b1) pulses++;
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic fresh();
        hold = 1'b1;
        step(2);
        hold = 1'b0;
        pulses = 0;
    endtask

    task automatic expect_pulses(input string t, input int e);
        checks++;
        if (pulses != e) begin
            fails++;
            $display("FAIL %s: pulse count actual %0d expected %0d", t, pulses, e);
        end
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        tag = "R1";
        step(3);
        checks++;
        if (timeout_req !== 1'b0) begin
            fails++;
            $display("FAIL R1: timeout_req actual %0b expected 0 in reset", timeout_req);
        end
        rst_n = 1'b1;
        step(5);

        tag = "R4"; sel = 2'b00; fresh(); step(40);
        expect_pulses("R4", 3);
        tag = "R7"; pulses = 0; step(36);
        expect_pulses("R7", 3);

        tag = "R5"; sel = 2'b01; fresh(); step(50);
        expect_pulses("R5", 2);

        tag = "R6"; sel = 2'b10; fresh(); step(70);
        expect_pulses("R6", 2);
        sel = 2'b11; fresh(); step(70);
        expect_pulses("R6", 2);

        tag = "R2"; sel = 2'b00; fresh();
        for (int i = 0; i < 10; i++) begin
            strobe = 1'b0; step(5); strobe = 1'b1; step(5);
        end
        expect_pulses("R2", 0);

        tag = "R2"; fresh(); strobe = 1'b0; step(40);
        expect_pulses("R2", 3);

        tag = "R3"; fresh(); strobe = 1'b1; step(40);
        expect_pulses("R3", 3);

        tag = "R8"; hold = 1'b1; pulses = 0; step(40);
        expect_pulses("R8", 0);
        hold = 1'b0; step(13);
        expect_pulses("R8", 1);

        tag = "R11"; fresh();
        for (int i = 0; i < 10; i++) begin
            strobe = 1'b0; step(1); strobe = 1'b1; step(9);
        end
        expect_pulses("R11", 0);

        tag = "R10"; sel = 2'b10; fresh(); step(25);
        sel = 2'b00; pulses = 0; step(4);
        expect_pulses("R10", 1);

        tag = "R9";
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 9) == 0) strobe = ~strobe;
            if ($urandom_range(0, 99) == 0) sel = 2'($urandom_range(0, 3));
            hold = ($urandom_range(0, 199) == 0);
            step(1);
        end
        hold = 1'b0;
        step(2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule